// File: doc/BRIEF.md
# Execute Packet Splitter and Unit Router

This block sits between an instruction memory and eight execution units of a very-long-instruction-word core. Each accepted fetch word is 256 bits wide and holds eight 32-bit instructions. The block cuts that word into execute packets and issues one packet per cycle. Bit 0 of each instruction is a chaining bit. When it is 1, the next higher slot joins the same packet. When it is 0, the packet closes at that slot. The top slot always closes its packet, so a packet never reaches into the next fetch word.

An instruction's lane is not set by its slot. Bits [4:2] of the instruction name its target unit, and the block places the instruction on that unit's lane. Two instructions in one packet may name the same unit. In that case the lower-slot instruction keeps the lane, the higher-slot one is discarded, and a conflict flag goes high with that issue. The block does no dependency checking of any kind.

On the fetch side the block uses a valid/ready handshake and holds one fetch word at a time. A fetch whose byte offset within a 32-byte line is nonzero is refused and reported.

Top module: `exec_packet_dispatch`

## Requirements
- R1: After reset, fp_ready is 1, and issue_valid, unit_valid, unit_insn, unit_conflict and fp_misalign are all 0.
- R2: A handshake (fp_valid and fp_ready both high) with fp_offset nonzero is discarded and issues nothing. fp_misalign is 1 for exactly the following cycle.
- R3: Within a fetch word, slot i and slot i+1 belong to the same execute packet when bit 0 of slot i is 1. Slot i ends its packet when that bit is 0.
- R4: With all eight chaining bits set, the word issues as one packet on all eight lanes. With none set, it issues as eight single-instruction packets on eight consecutive cycles.
- R5: Bit 0 of slot 7 is ignored. Slot 7 always closes its packet, and the next fetch word starts a new packet.
- R6: An instruction is placed on lane u, where u is its bits [4:2]. The lane codes are 0=L1, 1=L2, 2=S1, 3=S2, 4=M1, 5=M2, 6=D1 and 7=D2. Lane u occupies unit_insn[32u+31:32u], and unit_valid[u] marks it.
- R7: When several instructions in one packet name the same unit, the lowest slot keeps the lane and the others are dropped. unit_conflict is 1 in the same cycle as that packet's issue_valid, and 0 otherwise.
- R8: fp_ready is 1 when no fetch word is held, or in the cycle in which the last packet of the held word is being issued. Otherwise it is 0. A fetch offered in that last cycle is taken with no idle cycle between the two words' issues.
- R9: The first packet of an accepted word appears on the outputs two clock edges after the accepting edge. Further packets of the same word follow on consecutive cycles.
- R10: Issued instructions appear bit-for-bit unchanged, including bit 0. Lanes that are not valid read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_valid | input | 1 | Fetch word offered |
| fp_offset | input | 5 | Low byte-address bits of the fetch; must be zero |
| fp_data | input | 256 | Fetch word; slot s occupies bits [32s+31:32s] |
| fp_ready | output | 1 | Fetch word can be taken this cycle |
| fp_misalign | output | 1 | Previous-cycle fetch was refused for misalignment |
| issue_valid | output | 1 | An execute packet is on the lanes |
| unit_valid | output | 8 | Per-unit lane occupied |
| unit_insn | output | 256 | Per-unit instruction, lane u at [32u+31:32u] |
| unit_conflict | output | 1 | A same-unit collision dropped an instruction in this packet |

## Verification
The case hardest to reach from the ports is a fetch accepted in the very cycle that the previous word's last packet is leaving. To reach it, the stimulus keeps fp_valid high through the stall and swaps in the second word's data. The bench then checks that issues continue without a gap. A second hard case is a collision inside a packet that starts in the middle of the word. A word with mixed chaining bits and every instruction aimed at one unit creates this case. Here the drop rule must pick the lowest slot of that packet, not the lowest slot of the word.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
    localparam int unsigned SLOTS_DEF    = 8;
    localparam int unsigned INSN_W_DEF   = 32;
    localparam int unsigned UNIT_W_DEF   = 3;
    localparam int unsigned UNIT_LSB_DEF = 2;
endpackage

// File: rtl/packet_scan.sv
module packet_scan #(
    parameter int unsigned SLOTS = 8,
    localparam int unsigned PTR_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] chain,
    input  logic [PTR_W-1:0] start,
    output logic [SLOTS-1:0] member,
    output logic [PTR_W-1:0] last_idx,
    output logic             ends_word
);
    always_comb begin
        logic open;
        open     = 1'b1;
        member   = '0;
        last_idx = '0;
        for (int i = 0; i < int'(SLOTS); i++) begin
            if (open && (i >= int'(start))) begin
                member[i] = 1'b1;
                // top slot closes regardless of its chaining bit
                if (!chain[i] || (i == int'(SLOTS) - 1)) begin
                    open     = 1'b0;
                    last_idx = PTR_W'(i);
                end
            end
        end
        ends_word = (last_idx == PTR_W'(SLOTS - 1));
    end
endmodule

// File: rtl/unit_router.sv
module unit_router #(
    parameter int unsigned SLOTS    = 8,
    parameter int unsigned INSN_W   = 32,
    parameter int unsigned UNIT_W   = 3,
    parameter int unsigned UNIT_LSB = 2,
    localparam int unsigned UNITS   = 1 << UNIT_W
) (
    input  logic [SLOTS*INSN_W-1:0] word,
    input  logic [SLOTS-1:0]        member,
    output logic [UNITS-1:0]        lane_valid,
    output logic [UNITS*INSN_W-1:0] lane_insn,
    output logic                    clash
);
    always_comb begin
        logic [INSN_W-1:0] insn;
        logic [UNIT_W-1:0] u;
        lane_valid = '0;
        lane_insn  = '0;
        clash      = 1'b0;
        // ascending slot order: lowest slot wins a contested lane
        for (int s = 0; s < int'(SLOTS); s++) begin
            insn = word[s*INSN_W +: INSN_W];
            u    = insn[UNIT_LSB +: UNIT_W];
            if (member[s]) begin
                if (lane_valid[u]) begin
                    clash = 1'b1;
                end else begin
                    lane_valid[u]                        = 1'b1;
                    lane_insn[int'(u)*INSN_W +: INSN_W]  = insn;
                end
            end
        end
    end
endmodule

// File: rtl/exec_packet_dispatch.sv
module exec_packet_dispatch
    import dispatch_pkg::*;
#(
    parameter int unsigned SLOTS    = SLOTS_DEF,
    parameter int unsigned INSN_W   = INSN_W_DEF,
    parameter int unsigned UNIT_W   = UNIT_W_DEF,
    parameter int unsigned UNIT_LSB = UNIT_LSB_DEF,
    localparam int unsigned UNITS   = 1 << UNIT_W,
    localparam int unsigned FP_W    = SLOTS * INSN_W,
    localparam int unsigned ALIGN_W = $clog2(FP_W / 8),
    localparam int unsigned PTR_W   = $clog2(SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fp_valid,
    input  logic [ALIGN_W-1:0]      fp_offset,
    input  logic [FP_W-1:0]         fp_data,
    output logic                    fp_ready,
    output logic                    fp_misalign,
    output logic                    issue_valid,
    output logic [UNITS-1:0]        unit_valid,
    output logic [UNITS*INSN_W-1:0] unit_insn,
    output logic                    unit_conflict
);
    typedef struct packed {
        logic                    held;
        logic [PTR_W-1:0]        ptr;
        logic [FP_W-1:0]         word;
        logic                    issue;
        logic [UNITS-1:0]        uv;
        logic [UNITS*INSN_W-1:0] ui;
        logic                    clash;
        logic                    misalign;
    } state_t;

    state_t st_d, st_q;

    logic [SLOTS-1:0]        chain;
    logic [SLOTS-1:0]        member;
    logic [PTR_W-1:0]        last_idx;
    logic                    ends_word;
    logic [UNITS-1:0]        lane_valid;
    logic [UNITS*INSN_W-1:0] lane_insn;
    logic                    clash;
    logic                    take;
    logic                    bad_off;

    for (genvar g = 0; g < SLOTS; g++) begin : g_chain
        assign chain[g] = st_q.word[g*INSN_W];
    end

    packet_scan #(.SLOTS(SLOTS)) i_scan (
        .chain     (chain),
        .start     (st_q.ptr),
        .member    (member),
        .last_idx  (last_idx),
        .ends_word (ends_word)
    );

    unit_router #(
        .SLOTS    (SLOTS),
        .INSN_W   (INSN_W),
        .UNIT_W   (UNIT_W),
        .UNIT_LSB (UNIT_LSB)
    ) i_route (
        .word       (st_q.word),
        .member     (member),
        .lane_valid (lane_valid),
        .lane_insn  (lane_insn),
        .clash      (clash)
    );

    assign fp_ready = !st_q.held || ends_word;
    assign take     = fp_valid && fp_ready;
    assign bad_off  = |fp_offset;

    always_comb begin
        st_d          = st_q;
        st_d.issue    = st_q.held;
        st_d.uv       = st_q.held ? lane_valid : '0;
        st_d.ui       = st_q.held ? lane_insn  : '0;
        st_d.clash    = st_q.held && clash;
        st_d.misalign = take && bad_off;
        if (st_q.held) begin
            if (ends_word) begin
                st_d.held = 1'b0;
                st_d.ptr  = '0;
            end else begin
                st_d.ptr  = last_idx + PTR_W'(1);
            end
        end
        if (take && !bad_off) begin
            st_d.held = 1'b1;
            st_d.ptr  = '0;
            st_d.word = fp_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fp_misalign   = st_q.misalign;
    assign issue_valid   = st_q.issue;
    assign unit_valid    = st_q.uv;
    assign unit_insn     = st_q.ui;
    assign unit_conflict = st_q.clash;
endmodule

// File: rtl/dispatch_checks.sv
module dispatch_checks #(
    parameter int unsigned INSN_W   = 32,
    parameter int unsigned UNIT_W   = 3,
    parameter int unsigned UNIT_LSB = 2,
    parameter int unsigned ALIGN_W  = 5,
    localparam int unsigned UNITS   = 1 << UNIT_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    fp_valid,
    input logic [ALIGN_W-1:0]      fp_offset,
    input logic                    fp_ready,
    input logic                    fp_misalign,
    input logic                    issue_valid,
    input logic [UNITS-1:0]        unit_valid,
    input logic [UNITS*INSN_W-1:0] unit_insn,
    input logic                    unit_conflict
);
    assert_misalign_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_valid && fp_ready && (fp_offset != '0)) |=> fp_misalign);

    assert_misalign_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fp_misalign |-> $past(fp_valid && fp_ready));

    assert_packet_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (unit_valid != '0));

    assert_conflict_in_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unit_conflict |-> issue_valid);

    assert_stall_issues_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_ready |=> issue_valid);

    assert_first_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_valid && fp_ready && (fp_offset == '0)) |=> ##1 issue_valid);

    assert_idle_lanes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> ((unit_valid == '0) && (unit_insn == '0)));

    for (genvar u = 0; u < UNITS; u++) begin : g_lane
        assert_lane_unit_R6: assert property (@(posedge clk) disable iff (!rst_n)
            unit_valid[u] |-> (unit_insn[u*INSN_W + UNIT_LSB +: UNIT_W] == UNIT_W'(u)));
    end
endmodule

bind exec_packet_dispatch dispatch_checks #(
    .INSN_W   (INSN_W),
    .UNIT_W   (UNIT_W),
    .UNIT_LSB (UNIT_LSB),
    .ALIGN_W  (ALIGN_W)
) i_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .fp_valid      (fp_valid),
    .fp_offset     (fp_offset),
    .fp_ready      (fp_ready),
    .fp_misalign   (fp_misalign),
    .issue_valid   (issue_valid),
    .unit_valid    (unit_valid),
    .unit_insn     (unit_insn),
    .unit_conflict (unit_conflict)
);

// File: tb/test_exec_packet_dispatch.sv
module test_exec_packet_dispatch;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fp_valid = 1'b0;
    logic [4:0]   fp_offset = '0;
    logic [255:0] fp_data = '0;
    logic         fp_ready, fp_misalign, issue_valid, unit_conflict;
    logic [7:0]   unit_valid;
    logic [255:0] unit_insn;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    exec_packet_dispatch i_exec_packet_dispatch (
        .clk(clk), .rst_n(rst_n), .fp_valid(fp_valid), .fp_offset(fp_offset),
        .fp_data(fp_data), .fp_ready(fp_ready), .fp_misalign(fp_misalign),
        .issue_valid(issue_valid), .unit_valid(unit_valid), .unit_insn(unit_insn),
        .unit_conflict(unit_conflict)
    );

    // {chaining bits[31:24], unit codes[23:0] with slot s at [3s+2:3s]}
    localparam logic [31:0] VEC [6] = '{
        {8'hFF, 24'hFAC688},   // one packet, units 0..7 (R4)
        {8'h00, 24'h053977},   // eight single packets, units 7..0 (R4)
        {8'hE0, 24'hFAC688},   // slot 7 chaining bit ignored (R5)
        {8'h55, 24'h053977},   // four pairs (R3)
        {8'hFF, 24'h6DB6DB},   // whole word on unit 3 (R7)
        {8'h3B, 24'h000000}    // mid-word packets all on unit 0 (R7)
    };

    task automatic chk(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] build(int v, logic [7:0] par, logic [23:0] units);
        logic [255:0] d;
        for (int s = 0; s < 8; s++)
            d[s*32 +: 32] = {8'(v + 1), 8'(s * 3), 11'h2A5, units[3*s +: 3], 1'(s), par[s]};
        return d;
    endfunction

    task automatic run_word(int v, logic [7:0] par, logic [23:0] units);
        logic [255:0] d;
        logic [7:0]   emask [8];
        logic [255:0] elane [8];
        bit           econf [8];
        int           np = 0;
        bit           open = 0;
        logic         rprev;
        d = build(v, par, units);
        for (int s = 0; s < 8; s++) begin
            int u = int'(units[3*s +: 3]);
            if (!open) begin emask[np] = '0; elane[np] = '0; econf[np] = 0; open = 1; end
            if (emask[np][u]) econf[np] = 1;
            else begin emask[np][u] = 1'b1; elane[np][u*32 +: 32] = d[s*32 +: 32]; end
            if (!par[s] || s == 7) begin np++; open = 0; end
        end
        @(negedge clk);
        chk(fp_ready == 1'b1, "R8", "ready when empty", 256'(fp_ready), 256'(1));
        fp_valid = 1'b1; fp_offset = '0; fp_data = d;
        @(negedge clk);
        fp_valid = 1'b0;
        chk(issue_valid == 1'b0, "R9", "no issue one edge after accept", 256'(issue_valid), 256'(0));
        rprev = fp_ready;
        for (int j = 0; j < np; j++) begin
            @(negedge clk);
            chk(issue_valid == 1'b1, "R9", "packet issue", 256'(issue_valid), 256'(1));
            chk(unit_valid == emask[j], "R3", "lane mask", 256'(unit_valid), 256'(emask[j]));
            chk(unit_insn == elane[j], "R6", "lane contents", unit_insn, elane[j]);
            chk(unit_conflict == econf[j], "R7", "conflict flag", 256'(unit_conflict), 256'(econf[j]));
            chk(rprev == (j == np - 1), "R8", "ready only on last packet", 256'(rprev), 256'(j == np - 1));
            rprev = fp_ready;
        end
        @(negedge clk);
        chk(issue_valid == 1'b0, "R5", "word ends after last packet", 256'(issue_valid), 256'(0));
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [255:0] a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(fp_ready == 1'b1, "R1", "ready", 256'(fp_ready), 256'(1));
        chk({issue_valid, unit_conflict, fp_misalign} == 3'b0, "R1", "flags",
            256'({issue_valid, unit_conflict, fp_misalign}), 256'(0));
        chk(unit_valid == '0 && unit_insn == '0, "R1", "lanes", unit_insn, 256'(0));

        foreach (VEC[i]) run_word(i, VEC[i][31:24], VEC[i][23:0]);

        // R2 misaligned fetch refused
        @(negedge clk);
        fp_valid = 1'b1; fp_offset = 5'h04; fp_data = build(9, 8'hFF, 24'hFAC688);
        @(negedge clk);
        fp_valid = 1'b0; fp_offset = '0;
        chk(fp_misalign == 1'b1, "R2", "misalign flag", 256'(fp_misalign), 256'(1));
        chk(fp_ready == 1'b1, "R2", "nothing held", 256'(fp_ready), 256'(1));
        @(negedge clk);
        chk(fp_misalign == 1'b0, "R2", "flag one cycle", 256'(fp_misalign), 256'(0));
        chk(issue_valid == 1'b0, "R2", "no issue", 256'(issue_valid), 256'(0));
        @(negedge clk);
        chk(issue_valid == 1'b0, "R2", "still no issue", 256'(issue_valid), 256'(0));

        // R8 back-to-back: second word taken during last issue of first
        a = build(20, 8'h77, 24'hFAC688);
        b = build(21, 8'hFF, 24'h053977);
        @(negedge clk);
        fp_valid = 1'b1; fp_data = a;
        @(negedge clk);
        fp_data = b;
        chk(issue_valid == 1'b0 && fp_ready == 1'b0, "R8", "stall while packet 0 pending",
            256'({issue_valid, fp_ready}), 256'(0));
        @(negedge clk);
        chk(issue_valid == 1'b1 && unit_valid == 8'h0F, "R8", "first packet of word A",
            256'({issue_valid, unit_valid}), 256'({1'b1, 8'h0F}));
        chk(fp_ready == 1'b1, "R8", "ready on last packet", 256'(fp_ready), 256'(1));
        @(negedge clk);
        fp_valid = 1'b0;
        chk(issue_valid == 1'b1 && unit_valid == 8'hF0, "R8", "second packet of word A",
            256'({issue_valid, unit_valid}), 256'({1'b1, 8'hF0}));
        @(negedge clk);
        chk(issue_valid == 1'b1 && unit_valid == 8'hFF, "R8", "word B without gap",
            256'({issue_valid, unit_valid}), 256'({1'b1, 8'hFF}));
        chk(unit_insn[31:0] == b[255:224], "R10", "lane 0 from slot 7 unchanged",
            256'(unit_insn[31:0]), 256'(b[255:224]));
        @(negedge clk);
        chk(issue_valid == 1'b0 && fp_ready == 1'b1, "R8", "idle after word B",
            256'({issue_valid, fp_ready}), 256'({1'b0, 1'b1}));

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule